// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transmitter

This block is the device end of a PS/2 link in the device-to-host direction. Bytes arrive on a parallel valid/ready port and queue in a small holding buffer. The block sends each byte as an eleven-bit serial frame. It generates the link clock itself and drives both lines open-drain: each line has a pull-low enable going out and a sampled level coming back. All bit timing comes from a microsecond tick, and the tick is derived from a parameter that gives the number of system clocks per microsecond.

Before a frame starts, the block looks at both lines. If the host is holding the clock low, or the data line is low, the byte stays in the buffer and nothing is driven. The frame starts once both lines read high.

During each released-clock phase of a frame, the block samples the clock line on every system cycle. A host pull-low seen before the rising clock edge of the parity bit aborts the frame. The lines are released and the byte stays at the head of the buffer, so it is sent again later. A pull-low seen after that edge is ignored and the frame runs to completion.

Top module: `ps2_dev_tx`

## Requirements
- R1: A frame carries, in wire order, a start bit of 0, the eight data bits least-significant first, a parity bit and a stop bit of 1. Bit n is sampled by the host while the clock is low in the n-th low pulse, counting from 0.
- R2: The parity bit makes the count of ones over the eight data bits plus parity odd.
- R3: The start bit is placed on data with the clock released for T_SETUP_US µs before the first clock low. Each clock low lasts T_LOW_US µs. Each released gap between lows, and the final released interval before the frame ends, lasts T_HIGH_US µs. Every µs equals CLKS_PER_US system cycles. The defaults are 20, 40 and 35 µs, and elaboration rejects low times outside 30–50 µs, high times outside 30–40 µs and periods outside 60–80 µs.
- R4: A frame starts only while both the sampled clock line and the sampled data line are high. While either is low, the buffered bytes stay queued, busy stays 0 and neither line is pulled.
- R5: If the host holds the clock low during a released phase that comes before the parity bit's rising clock edge, the frame is aborted within a few cycles. Both pull enables and busy drop, no frame-done pulse is given, and the same byte is later sent again in full.
- R6: If the host holds the clock low after the parity bit's rising clock edge, the frame completes normally with a frame-done pulse, and the byte is not sent again.
- R7: The buffer holds DEPTH bytes. in_ready is 1 exactly when the buffer is not full, and bytes are sent in the order they were accepted.
- R8: busy is 1 from the start of a frame until it completes or aborts. The pull enables are asserted only while busy is 1. frame_done is a one-cycle pulse in the cycle after a completed frame.
- R9: After reset, busy is 0, frame_done is 0, both pull enables are 0 and in_ready is 1.
- R10: A byte accepted in the same cycle that a completed frame removes its byte from the buffer is kept, and it is sent as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered on in_data |
| in_ready | output | 1 | Buffer can accept a byte |
| in_data | input | 8 | Byte to send |
| line_clk_in | input | 1 | Sampled level of the link clock line |
| line_clk_pull | output | 1 | Pull the link clock line low |
| line_dat_in | input | 1 | Sampled level of the link data line |
| line_dat_pull | output | 1 | Pull the link data line low |
| busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | One-cycle pulse after a completed frame |

## Verification
Two functions can fall in the same cycle: a completed frame popping the head of the buffer, and a new byte being accepted. The bench computes the exact frame length from the timing parameters and raises in_valid so that the byte is taken on the popping edge. It then expects in_ready to remain 1 and the new byte, not the old one, to appear as the next frame. The inhibit boundary is provoked the same way: the host model pulls the clock low right after the ninth and then the tenth released edge. One must abort and the other must complete.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

   localparam int BYTE_W     = 8;
   localparam int FRAME_BITS = 11;
   localparam int DECIDE_IDX = 9;   // parity bit: its rising edge is the commit point

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_HIGH,
      PH_LOW,
      PH_TAIL
   } phase_t;

   function automatic logic [FRAME_BITS-1:0] build_frame(input logic [BYTE_W-1:0] b);
      return {1'b1, ~(^b), b, 1'b0};
   endfunction

endpackage

// File: rtl/ps2_tx_sync.sv
module ps2_tx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ps2_tx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b1;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/ps2_tx_fifo.sv
module ps2_tx_fifo #(
   parameter int DEPTH = 2,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         full,
   output logic         nonempty,
   output logic [W-1:0] head
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("ps2_tx_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem_q[wr_q] <= push_data;
   end

   assign full     = (int'(cnt_q) == DEPTH);
   assign nonempty = (cnt_q != '0);
   assign head     = mem_q[rd_q];

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= DEPTH);

   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt_q != '0));

endmodule

// File: rtl/ps2_tx_engine.sv
module ps2_tx_engine
   import ps2_tx_pkg::*;
#(
   parameter int CLKS_PER_US = 125,
   parameter int T_SETUP_US  = 20,
   parameter int T_LOW_US    = 40,
   parameter int T_HIGH_US   = 35,
   parameter int GUARD       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              have_byte,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              clk_s,
   input  logic              dat_s,
   output logic              pop,
   output logic              clk_oe,
   output logic              dat_oe,
   output logic              busy,
   output logic              done
);

   localparam int MAX_US = (T_SETUP_US > T_LOW_US) ?
                           ((T_SETUP_US > T_HIGH_US) ? T_SETUP_US : T_HIGH_US) :
                           ((T_LOW_US > T_HIGH_US) ? T_LOW_US : T_HIGH_US);
   localparam int UW = $clog2(MAX_US + 1);
   localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
   localparam int GW = $clog2(GUARD + 1);
   localparam logic [3:0] LAST_IDX = 4'(FRAME_BITS - 1);

   phase_t                phase_q, phase_n;
   logic [3:0]            idx_q, idx_n, idx_inc;
   logic [UW-1:0]         us_q, us_n;
   logic [PW-1:0]         pre_q, pre_n;
   logic [GW-1:0]         grd_q, grd_n;
   logic [FRAME_BITS-1:0] frm_q, frm_n, frm_new;
   logic                  clk_oe_q, clk_oe_n, dat_oe_q, dat_oe_n, done_q;
   logic                  tick, ph_end, grd_ok, inhibit;
   int                    lim;

   always_comb begin
      tick    = (int'(pre_q) == CLKS_PER_US - 1);
      grd_ok  = (int'(grd_q) >= GUARD);
      idx_inc = idx_q + 4'd1;
      frm_new = build_frame(byte_in);
      unique case (phase_q)
         PH_HIGH: lim = (idx_q == 4'd0) ? T_SETUP_US : T_HIGH_US;
         PH_LOW:  lim = T_LOW_US;
         default: lim = T_HIGH_US;
      endcase
      ph_end  = tick && (int'(us_q) == lim - 1);
      inhibit = (phase_q == PH_HIGH) && grd_ok && !clk_s && (idx_q <= 4'(DECIDE_IDX));
   end

   always_comb begin
      phase_n  = phase_q;
      idx_n    = idx_q;
      frm_n    = frm_q;
      clk_oe_n = clk_oe_q;
      dat_oe_n = dat_oe_q;
      pre_n    = tick ? '0 : pre_q + 1'b1;
      us_n     = tick ? us_q + 1'b1 : us_q;
      grd_n    = grd_ok ? grd_q : grd_q + 1'b1;
      pop      = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            pre_n = '0;
            us_n  = '0;
            grd_n = '0;
            if (have_byte && clk_s && dat_s) begin
               phase_n  = PH_HIGH;
               idx_n    = '0;
               frm_n    = frm_new;
               dat_oe_n = ~frm_new[0];
            end
         end
         PH_HIGH: begin
            if (inhibit) begin
               phase_n  = PH_IDLE;
               clk_oe_n = 1'b0;
               dat_oe_n = 1'b0;
            end else if (ph_end) begin
               phase_n  = PH_LOW;
               clk_oe_n = 1'b1;
               pre_n    = '0;
               us_n     = '0;
               grd_n    = '0;
            end
         end
         PH_LOW: begin
            if (ph_end) begin
               pre_n    = '0;
               us_n     = '0;
               grd_n    = '0;
               clk_oe_n = 1'b0;
               if (idx_q == LAST_IDX) begin
                  phase_n  = PH_TAIL;
                  dat_oe_n = 1'b0;
               end else begin
                  phase_n  = PH_HIGH;
                  idx_n    = idx_inc;
                  dat_oe_n = ~frm_q[idx_inc];
               end
            end
         end
         default: begin
            if (ph_end) begin
               phase_n = PH_IDLE;
               pop     = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         idx_q    <= '0;
         us_q     <= '0;
         pre_q    <= '0;
         grd_q    <= '0;
         frm_q    <= '0;
         clk_oe_q <= 1'b0;
         dat_oe_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         phase_q  <= phase_n;
         idx_q    <= idx_n;
         us_q     <= us_n;
         pre_q    <= pre_n;
         grd_q    <= grd_n;
         frm_q    <= frm_n;
         clk_oe_q <= clk_oe_n;
         dat_oe_q <= dat_oe_n;
         done_q   <= pop;
      end
   end

   assign clk_oe = clk_oe_q;
   assign dat_oe = dat_oe_q;
   assign busy   = (phase_q != PH_IDLE);
   assign done   = done_q;

   assert_start_lines_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(clk_s && dat_s && have_byte));

   assert_early_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HIGH && idx_q <= 4'(DECIDE_IDX) && grd_ok && !clk_s)
      |=> (!busy && !clk_oe_q && !dat_oe_q && !done_q));

   assert_late_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx_q == LAST_IDX) |=> (busy || done_q));

   assert_stop_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HIGH && idx_q == LAST_IDX) |-> !dat_oe_q);

   assert_pull_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_oe_q || dat_oe_q) |-> busy);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
   import ps2_tx_pkg::*;
#(
   parameter int CLKS_PER_US = 125,
   parameter int DEPTH       = 2,
   parameter int T_SETUP_US  = 20,
   parameter int T_LOW_US    = 40,
   parameter int T_HIGH_US   = 35,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              line_clk_in,
   output logic              line_clk_pull,
   input  logic              line_dat_in,
   output logic              line_dat_pull,
   output logic              busy,
   output logic              frame_done
);

   localparam int GUARD = SYNC_STAGES + 1;

   if (CLKS_PER_US < 1) begin : g_bad_rate
      $error("ps2_dev_tx: CLKS_PER_US must be at least 1");
   end
   if (T_LOW_US < 30 || T_LOW_US > 50) begin : g_bad_low
      $error("ps2_dev_tx: clock low time outside 30..50 us");
   end
   if (T_HIGH_US < 30 || T_HIGH_US > 40) begin : g_bad_high
      $error("ps2_dev_tx: clock high time outside 30..40 us");
   end
   if (T_LOW_US + T_HIGH_US < 60 || T_LOW_US + T_HIGH_US > 80) begin : g_bad_period
      $error("ps2_dev_tx: clock period outside 60..80 us");
   end
   if (T_SETUP_US < 1 || T_SETUP_US > T_HIGH_US) begin : g_bad_setup
      $error("ps2_dev_tx: setup time must be 1..T_HIGH_US us");
   end

   logic              clk_s, dat_s, pop, full, nonempty, push;
   logic [BYTE_W-1:0] head;

   ps2_tx_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d_in(line_clk_in), .d_out(clk_s));

   ps2_tx_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d_in(line_dat_in), .d_out(dat_s));

   assign in_ready = !full;
   assign push     = in_valid && !full;

   ps2_tx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_data(in_data), .pop(pop),
      .full(full), .nonempty(nonempty), .head(head));

   ps2_tx_engine #(
      .CLKS_PER_US(CLKS_PER_US),
      .T_SETUP_US (T_SETUP_US),
      .T_LOW_US   (T_LOW_US),
      .T_HIGH_US  (T_HIGH_US),
      .GUARD      (GUARD)
   ) u_engine (
      .clk(clk), .rst_n(rst_n),
      .have_byte(nonempty), .byte_in(head),
      .clk_s(clk_s), .dat_s(dat_s),
      .pop(pop), .clk_oe(line_clk_pull), .dat_oe(line_dat_pull),
      .busy(busy), .done(frame_done));

endmodule

// File: tb/ps2_dev_tx_test.sv
module ps2_dev_tx_test;

   localparam int C     = 1;
   localparam int DEPTH = 2;
   localparam int SETU  = 20;
   localparam int LOWU  = 40;
   localparam int HIGHU = 35;
   localparam int FRAME_CYC = (SETU + 11 * LOWU + 11 * HIGHU) * C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic host_clk = 1'b0, host_dat = 1'b0;
   logic in_ready, clk_pull, dat_pull, busy, done;
   wire  clk_line = !(clk_pull || host_clk);
   wire  dat_line = !(dat_pull || host_dat);

   always #4 clk = ~clk;

   ps2_dev_tx #(.CLKS_PER_US(C), .DEPTH(DEPTH), .T_SETUP_US(SETU),
                .T_LOW_US(LOWU), .T_HIGH_US(HIGHU), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .line_clk_in(clk_line), .line_clk_pull(clk_pull),
      .line_dat_in(dat_line), .line_dat_pull(dat_pull),
      .busy(busy), .frame_done(done));

   int total = 0, fails = 0;
   bit finished = 0;
   logic [7:0] exp_q[$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   // host-side monitor, all sampling on the falling system clock edge
   int cyc = 0, t_last = 0, nbits = 0, nfall = 0, nrise = 0, tbad = 0;
   int ndone = 0, naborts = 0, nstarts = 0, own_bad = 0, pulse_bad = 0;
   logic [10:0] bits = '0;
   logic pb = 0, pco = 0, pd = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (busy && !pb) begin
            nbits = 0; nfall = 0; nrise = 0; tbad = 0; t_last = cyc; nstarts++;
         end
         if (clk_pull && !pco) begin
            if (cyc - t_last != ((nrise == 0) ? SETU : HIGHU) * C) tbad++;
            t_last = cyc;
            if (nbits < 11) bits[nbits] = dat_line;
            nbits++; nrise++;
         end
         if (!clk_pull && pco) begin
            if (cyc - t_last != LOWU * C) tbad++;
            t_last = cyc;
            nfall++;
         end
         if (done && !pd) begin
            logic [7:0] e;
            if (cyc - t_last != HIGHU * C) tbad++;
            ndone++;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
            check(tbad == 0, "R3 bit timing", tbad, 0);
            check(nbits == 11 && bits[0] == 1'b0 && bits[10] == 1'b1 && bits[8:1] == e,
                  "R1 frame content", int'(bits), int'({1'b1, ~(^e), e, 1'b0}));
            check(^bits[9:1] == 1'b1, "R2 odd parity", int'(bits[9]), int'(~(^e)));
         end
         if (done && pd) pulse_bad++;
         if (!busy && pb && !done) naborts++;
         if ((clk_pull || dat_pull) && !busy) own_bad++;
      end
      pb = busy; pco = clk_pull; pd = done;
   end

   task automatic push(input logic [7:0] b);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = b;
      exp_q.push_back(b);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_idle;
      wait (exp_q.size() == 0);
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         fails++; total++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int d0, a0, s0;
      repeat (3) @(negedge clk);
      check(!busy && !done && !clk_pull && !dat_pull, "R9 reset outputs in reset",
            {busy, done, clk_pull, dat_pull}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(!busy && !done && !clk_pull && !dat_pull && in_ready, "R9 after reset",
            {busy, done, clk_pull, dat_pull, in_ready}, 1);

      // sweep of byte patterns, streamed back to back (R1 R2 R3 R7)
      d0 = ndone;
      push(8'h00); push(8'hFF);
      for (int i = 0; i < 8; i++) push(8'(1 << i));
      for (int i = 0; i < 26; i++) push(8'(i * 29 + 3));
      wait_idle();
      check(ndone - d0 == 36, "R7 all queued bytes sent in order", ndone - d0, 36);

      // clock inhibited before start: buffer fills, nothing sent (R4 R7)
      host_clk = 1'b1;
      d0 = ndone; s0 = nstarts;
      push(8'hC3); push(8'h3C);
      @(negedge clk);
      check(!in_ready, "R7 ready low when buffer full", in_ready, 0);
      repeat (200) @(negedge clk);
      check(!busy && nstarts == s0 && !clk_pull && !dat_pull, "R4 held while clock inhibited",
            nstarts - s0, 0);
      host_clk = 1'b0;
      wait_idle();
      check(ndone - d0 == 2, "R4 held bytes sent after release", ndone - d0, 2);

      // data line low before start (R4)
      host_dat = 1'b1;
      s0 = nstarts;
      push(8'h96);
      repeat (100) @(negedge clk);
      check(!busy && nstarts == s0, "R4 held while data low", nstarts - s0, 0);
      host_dat = 1'b0;
      wait_idle();

      // inhibit in the released phase just before parity's rising edge (R5)
      d0 = ndone; a0 = naborts;
      push(8'h6E);
      wait (busy && nfall == 9);
      host_clk = 1'b1;
      repeat (8) @(negedge clk);
      check(!busy && !clk_pull && !dat_pull, "R5 lines released on abort",
            {busy, clk_pull, dat_pull}, 0);
      check(naborts - a0 == 1 && ndone == d0 && exp_q.size() == 1, "R5 aborted without done",
            ndone - d0, 0);
      repeat (60) @(negedge clk);
      host_clk = 1'b0;
      wait_idle();
      check(ndone - d0 == 1, "R5 byte resent after abort", ndone - d0, 1);

      // inhibit right after parity's rising edge (R6)
      d0 = ndone; a0 = naborts;
      push(8'hB1);
      wait (busy && nfall == 10);
      host_clk = 1'b1;
      repeat (50) @(negedge clk);
      host_clk = 1'b0;
      wait_idle();
      s0 = nstarts;
      repeat (1000) @(negedge clk);
      check(ndone - d0 == 1 && naborts == a0, "R6 late inhibit completes", naborts - a0, 0);
      check(nstarts == s0 && !busy, "R6 byte not resent", nstarts - s0, 0);

      // push in the same cycle as the completing pop (R10)
      d0 = ndone; s0 = nstarts;
      push(8'h47);
      @(negedge clk);
      while (!busy) @(negedge clk);
      repeat (FRAME_CYC - 1) @(negedge clk);
      in_valid = 1'b1; in_data = 8'hD8;
      exp_q.push_back(8'hD8);
      @(negedge clk);
      in_valid = 1'b0;
      check(done && in_ready, "R10 pop and push same cycle", {done, in_ready}, 3);
      wait_idle();
      check(ndone - d0 == 2 && nstarts - s0 == 2, "R10 new byte sent next",
            ndone - d0, 2);

      check(own_bad == 0, "R8 pulls only while busy", own_bad, 0);
      check(pulse_bad == 0, "R8 done is one cycle", pulse_bad, 0);

      finished = 1;
      summary();
      $finish;
   end

endmodule